// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block connects a synchronous request port to an external asynchronous static RAM of 128K words by 16 bits. The RAM is controlled by active-low chip select, output enable, write enable and one strobe per byte lane. A requester presents a word address, write data, a two-bit lane mask and a direction flag with a valid/ready handshake. The controller turns each request into one RAM access. It counts controller clock cycles to meet the RAM's pulse widths, access times and bus release delays. Each access ends with a one-cycle done pulse, and reads return their data with that pulse.

The shared data bus is presented at the pad boundary as three parts: a 16-bit output value, one output-enable bit per byte lane, and a 16-bit input value. The pad ring builds the three-state bus from these. Lanes are gated separately. A lane outside the mask keeps its strobe inactive, is never driven, and reads back as zero. A request whose mask selects no lane is consumed and answered with an error pulse, and the RAM pins stay idle.

All timing windows are cycle-count parameters. With the defaults and a 10 ns clock, the write strobe stays low for 60 ns and read data is sampled 80 ns after the strobes assert.

Top module: `sram_lane_ctrl`

## Requirements
- R1: While reset is active and right after it, chip select, output enable, write enable and both lane strobes are high, no lane output enable is set, req_ready_o is 1, and rsp_done_o and rsp_err_o are 0.
- R2: A write uses one setup cycle, then WE_LOW_CYC (default 6) cycles with write enable low, then one hold cycle with write enable high. Chip select and the selected strobes are low through all three phases. Output enable stays high for the whole write. ram_addr_o does not change while chip select is low.
- R3: Mask bit 0 selects the lower lane (data bits 7:0, strobe ram_lb_n_o, output enable bit 0). Mask bit 1 selects the upper lane (bits 15:8, ram_ub_n_o, output enable bit 1). A lane whose bit is 0 keeps its strobe high and its output enable 0, so a one-lane write leaves the other byte of the word unchanged.
- R4: A selected lane's output enable rises only after write enable has been low for WE_HIZ_CYC (default 3) cycles. It stays set through the hold cycle and clears in the cycle after it. It is never set while output enable is low or chip select is high, and never within three cycles of the RAM driving that lane.
- R5: A read holds chip select and output enable low, write enable high and the selected strobes low for RD_SAMPLE_CYC (default 8) cycles. The data bus is sampled at the end of the last of these cycles. rsp_rdata_o is valid in the following cycle together with rsp_done_o, and a lane outside the mask reads as zero.
- R6: rsp_done_o pulses for one cycle after each completed access, in the cycle where chip select has returned high. req_ready_o is 0 from the cycle after an accepted access until that pulse.
- R7: A request with mask 00 is accepted. It gives a one-cycle rsp_err_o pulse in the next cycle and no rsp_done_o. Chip select and all lane output enables stay inactive, and the RAM contents do not change.
- R8: Chip select falls one cycle after the handshake cycle. The exception is a write whose previous completed access was a read: it gets one extra cycle with chip select high, so chip select falls two cycles after the handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Controller idle, request accepted when valid |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 17 | Word address |
| req_wdata_i | input | 16 | Write data |
| req_mask_i | input | 2 | Lane select, bit 0 lower byte, bit 1 upper byte |
| rsp_done_o | output | 1 | Access complete pulse |
| rsp_err_o | output | 1 | Empty-mask rejection pulse |
| rsp_rdata_o | output | 16 | Read data, valid with rsp_done_o after a read |
| ram_addr_o | output | 17 | RAM address |
| ram_ce_n_o | output | 1 | RAM chip select, active low |
| ram_oe_n_o | output | 1 | RAM output enable, active low |
| ram_we_n_o | output | 1 | RAM write enable, active low |
| ram_lb_n_o | output | 1 | Lower lane strobe, active low |
| ram_ub_n_o | output | 1 | Upper lane strobe, active low |
| ram_dq_o | output | 16 | Value for the data bus pads |
| ram_dq_oe_o | output | 2 | Per-lane pad output enable |
| ram_dq_i | input | 16 | Value seen on the data bus pads |

## Verification
A wrong state or phase count shows at the pins within the access it corrupts. Write-enable or read-strobe windows come out with the wrong length, and chip select falls one cycle early or late after a read. Done arrives out of step with the rising chip select. A lane gating fault shows in two ways: a strobe or output enable moves on an unselected lane, or a later read-back returns a byte that should have been kept. Both appear no later than the next read of that word. A missing bus-release delay shows as the controller driving a lane while the modelled RAM may still be driving it.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_GAP,
    ST_WR_SETUP,
    ST_WR_PULSE,
    ST_WR_HOLD,
    ST_RD_STROBE
  } ctrl_state_e;

  // internal pin intent, active high
  typedef struct packed {
    logic sel;
    logic out_en;
    logic wr_en;
    logic strobe;
    logic drive;
    logic capture;
  } pin_ctl_t;

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  output logic [CNT_W-1:0] cnt_o
);

  localparam logic [CNT_W-1:0] CntMax = '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o <= '0;
    end else if (clear_i) begin
      cnt_o <= '0;
    end else if (cnt_o != CntMax) begin
      cnt_o <= cnt_o + 1'b1;
    end
  end

endmodule

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int WE_LOW_CYC    = 6,
  parameter int WE_HIZ_CYC    = 3,
  parameter int RD_SAMPLE_CYC = 8,
  parameter int CNT_W         = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic             req_write_i,
  input  logic             mask_zero_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             req_ready_o,
  output logic             accept_o,
  output logic             timer_clear_o,
  output pin_ctl_t         ctl_o,
  output logic             done_o,
  output logic             err_o
);

  ctrl_state_e state_q, state_d;
  logic        rd_last_q;
  logic        we_last, rd_last;

  assign req_ready_o = (state_q == ST_IDLE);
  assign accept_o    = req_valid_i && req_ready_o;
  assign we_last     = (cnt_i == CNT_W'(WE_LOW_CYC - 1));
  assign rd_last     = (cnt_i == CNT_W'(RD_SAMPLE_CYC - 1));

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (accept_o && !mask_zero_i) begin
          if (req_write_i) state_d = rd_last_q ? ST_GAP : ST_WR_SETUP;
          else             state_d = ST_RD_STROBE;
        end
      end
      ST_GAP:       state_d = ST_WR_SETUP;
      ST_WR_SETUP:  state_d = ST_WR_PULSE;
      ST_WR_PULSE:  if (we_last) state_d = ST_WR_HOLD;
      ST_WR_HOLD:   state_d = ST_IDLE;
      ST_RD_STROBE: if (rd_last) state_d = ST_IDLE;
      default:      state_d = ST_IDLE;
    endcase
  end

  assign timer_clear_o = (state_d != state_q);

  always_comb begin
    ctl_o         = '0;
    ctl_o.sel     = (state_q == ST_WR_SETUP) || (state_q == ST_WR_PULSE) ||
                    (state_q == ST_WR_HOLD)  || (state_q == ST_RD_STROBE);
    ctl_o.strobe  = ctl_o.sel;
    ctl_o.out_en  = (state_q == ST_RD_STROBE);
    ctl_o.wr_en   = (state_q == ST_WR_PULSE);
    ctl_o.drive   = ((state_q == ST_WR_PULSE) && (cnt_i >= CNT_W'(WE_HIZ_CYC))) ||
                    (state_q == ST_WR_HOLD);
    ctl_o.capture = (state_q == ST_RD_STROBE) && rd_last;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      rd_last_q <= 1'b0;
      done_o    <= 1'b0;
      err_o     <= 1'b0;
    end else begin
      state_q <= state_d;
      done_o  <= (state_q == ST_WR_HOLD) || ctl_o.capture;
      err_o   <= accept_o && mask_zero_i;
      if (ctl_o.capture)              rd_last_q <= 1'b1;
      else if (state_d == ST_WR_SETUP) rd_last_q <= 1'b0;
    end
  end

  assert_zero_mask_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_o && mask_zero_i) |=> (state_q == ST_IDLE));

  assert_we_window_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WR_PULSE) |-> (cnt_i < CNT_W'(WE_LOW_CYC)));

  assert_done_err_excl_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && err_o));

  assert_gap_before_write_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_GAP) |=> (state_q == ST_WR_SETUP));

endmodule

// File: rtl/sram_lane_io.sv
module sram_lane_io #(
  parameter int LANES  = 2,
  parameter int LANE_W = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    load_i,
  input  logic [LANES*LANE_W-1:0] wdata_i,
  input  logic [LANES-1:0]        mask_i,
  input  logic                    strobe_i,
  input  logic                    drive_i,
  input  logic                    capture_i,
  input  logic [LANES*LANE_W-1:0] dq_i,
  output logic [LANES-1:0]        strobe_n_o,
  output logic [LANES*LANE_W-1:0] dq_o,
  output logic [LANES-1:0]        dq_oe_o,
  output logic [LANES*LANE_W-1:0] rdata_o
);

  localparam int DataW = LANES * LANE_W;

  logic [LANES-1:0] mask_q;
  logic [DataW-1:0] wdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q  <= '0;
      wdata_q <= '0;
    end else if (load_i) begin
      mask_q  <= mask_i;
      wdata_q <= wdata_i;
    end
  end

  assign dq_o = wdata_q;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign strobe_n_o[l] = ~(strobe_i && mask_q[l]);
    assign dq_oe_o[l]    = drive_i && mask_q[l];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        rdata_o[l*LANE_W +: LANE_W] <= '0;
      end else if (capture_i) begin
        rdata_o[l*LANE_W +: LANE_W] <= mask_q[l] ? dq_i[l*LANE_W +: LANE_W] : '0;
      end
    end

    assert_lane_drive_strobed_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      dq_oe_o[l] |-> !strobe_n_o[l]);
  end

endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W        = 17,
  parameter int LANE_W        = 8,
  parameter int WE_LOW_CYC    = 6,
  parameter int WE_HIZ_CYC    = 3,
  parameter int RD_SAMPLE_CYC = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       req_valid_i,
  output logic                       req_ready_o,
  input  logic                       req_write_i,
  input  logic [ADDR_W-1:0]          req_addr_i,
  input  logic [2*LANE_W-1:0]        req_wdata_i,
  input  logic [1:0]                 req_mask_i,
  output logic                       rsp_done_o,
  output logic                       rsp_err_o,
  output logic [2*LANE_W-1:0]        rsp_rdata_o,
  output logic [ADDR_W-1:0]          ram_addr_o,
  output logic                       ram_ce_n_o,
  output logic                       ram_oe_n_o,
  output logic                       ram_we_n_o,
  output logic                       ram_lb_n_o,
  output logic                       ram_ub_n_o,
  output logic [2*LANE_W-1:0]        ram_dq_o,
  output logic [1:0]                 ram_dq_oe_o,
  input  logic [2*LANE_W-1:0]        ram_dq_i
);

  localparam int Lanes  = 2;
  localparam int MaxCyc = (WE_LOW_CYC > RD_SAMPLE_CYC) ? WE_LOW_CYC : RD_SAMPLE_CYC;
  localparam int CntW   = $clog2(MaxCyc + 1);

  pin_ctl_t            ctl;
  logic                accept, timer_clear;
  logic [CntW-1:0]     cnt;
  logic [Lanes-1:0]    strobe_n;
  logic [ADDR_W-1:0]   addr_q;

  sram_ctrl_fsm #(
    .WE_LOW_CYC    (WE_LOW_CYC),
    .WE_HIZ_CYC    (WE_HIZ_CYC),
    .RD_SAMPLE_CYC (RD_SAMPLE_CYC),
    .CNT_W         (CntW)
  ) i_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .req_valid_i   (req_valid_i),
    .req_write_i   (req_write_i),
    .mask_zero_i   (req_mask_i == '0),
    .cnt_i         (cnt),
    .req_ready_o   (req_ready_o),
    .accept_o      (accept),
    .timer_clear_o (timer_clear),
    .ctl_o         (ctl),
    .done_o        (rsp_done_o),
    .err_o         (rsp_err_o)
  );

  sram_phase_timer #(.CNT_W(CntW)) i_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (timer_clear),
    .cnt_o   (cnt)
  );

  sram_lane_io #(.LANES(Lanes), .LANE_W(LANE_W)) i_lanes (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (accept),
    .wdata_i    (req_wdata_i),
    .mask_i     (req_mask_i),
    .strobe_i   (ctl.strobe),
    .drive_i    (ctl.drive),
    .capture_i  (ctl.capture),
    .dq_i       (ram_dq_i),
    .strobe_n_o (strobe_n),
    .dq_o       (ram_dq_o),
    .dq_oe_o    (ram_dq_oe_o),
    .rdata_o    (rsp_rdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     addr_q <= '0;
    else if (accept) addr_q <= req_addr_i;
  end

  assign ram_addr_o = addr_q;
  assign ram_ce_n_o = ~ctl.sel;
  assign ram_oe_n_o = ~ctl.out_en;
  assign ram_we_n_o = ~ctl.wr_en;
  assign ram_lb_n_o = strobe_n[0];
  assign ram_ub_n_o = strobe_n[1];

  assert_oe_high_in_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ram_we_n_o |-> (ram_oe_n_o && !ram_ce_n_o));

  assert_addr_stable_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ram_ce_n_o && $past(!ram_ce_n_o)) |-> $stable(ram_addr_o));

  assert_drive_window_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|ram_dq_oe_o) |-> (ram_oe_n_o && !ram_ce_n_o));

  assert_drive_after_we_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(|ram_dq_oe_o) |-> (!ram_we_n_o && $past(!ram_we_n_o)));

  assert_read_we_high_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ram_oe_n_o |-> (ram_we_n_o && !ram_ce_n_o));

endmodule

// File: tb/test_sram_lane_ctrl.sv
module test_sram_lane_ctrl;

  localparam int WE_LOW  = 6;
  localparam int WE_HIZ  = 3;
  localparam int RD_SMP  = 8;
  localparam int HIZ_GRD = 3;

  typedef struct packed {
    logic        is_err;
    logic        is_read;
    logic [15:0] rdata;
  } exp_t;

  logic        clk, rst_n;
  logic        req_valid, req_ready, req_write;
  logic [16:0] req_addr;
  logic [15:0] req_wdata;
  logic [1:0]  req_mask;
  logic        rsp_done, rsp_err;
  logic [15:0] rsp_rdata;
  logic [16:0] ram_addr;
  logic        ce_n, oe_n, we_n, lb_n, ub_n;
  logic [15:0] dq_out, dq_in;
  logic [1:0]  dq_oe;

  sram_lane_ctrl i_sram_lane_ctrl (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .req_valid_i (req_valid),
    .req_ready_o (req_ready),
    .req_write_i (req_write),
    .req_addr_i  (req_addr),
    .req_wdata_i (req_wdata),
    .req_mask_i  (req_mask),
    .rsp_done_o  (rsp_done),
    .rsp_err_o   (rsp_err),
    .rsp_rdata_o (rsp_rdata),
    .ram_addr_o  (ram_addr),
    .ram_ce_n_o  (ce_n),
    .ram_oe_n_o  (oe_n),
    .ram_we_n_o  (we_n),
    .ram_lb_n_o  (lb_n),
    .ram_ub_n_o  (ub_n),
    .ram_dq_o    (dq_out),
    .ram_dq_oe_o (dq_oe),
    .ram_dq_i    (dq_in)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // ---------------- RAM model and reference ----------------
  logic [15:0] ram_mem [logic [16:0]];
  logic [15:0] ref_mem [logic [16:0]];

  function automatic logic [15:0] seed_word(input logic [16:0] a);
    return a[15:0] ^ 16'hA5C3 ^ {15'd0, a[16]};
  endfunction

  function automatic logic [15:0] ram_rd(input logic [16:0] a);
    if (ram_mem.exists(a)) return ram_mem[a];
    return seed_word(a);
  endfunction

  function automatic logic [15:0] ref_rd(input logic [16:0] a);
    if (ref_mem.exists(a)) return ref_mem[a];
    return seed_word(a);
  endfunction

  logic [1:0]  ram_act;
  logic [15:0] ram_word;
  always @(*) begin
    ram_act[0] = !ce_n && !oe_n && we_n && !lb_n;
    ram_act[1] = !ce_n && !oe_n && we_n && !ub_n;
    ram_word   = ram_rd(ram_addr);
    dq_in      = {ram_act[1] ? ram_word[15:8] : 8'h00,
                  ram_act[0] ? ram_word[7:0]  : 8'h00};
  end

  // ---------------- scoreboard state ----------------
  exp_t        exp_q[$];
  int          hs_cyc = 0;
  int          exp_delay = 1;
  logic [1:0]  cur_mask = 2'b00;
  bit          last_read = 0;

  task automatic do_req(input bit wr, input logic [16:0] a,
                        input logic [15:0] d, input logic [1:0] m);
    exp_t        e;
    logic [15:0] w;
    @(negedge clk);
    req_valid = 1'b1;
    req_write = wr;
    req_addr  = a;
    req_wdata = d;
    req_mask  = m;
    while (!req_ready) @(negedge clk);
    hs_cyc    = cyc;
    cur_mask  = m;
    exp_delay = (wr && last_read) ? 2 : 1;
    w = ref_rd(a);
    e.is_err  = (m == 2'b00);
    e.is_read = !wr;
    e.rdata   = {m[1] ? w[15:8] : 8'h00, m[0] ? w[7:0] : 8'h00};
    exp_q.push_back(e);
    if (m != 2'b00) begin
      if (wr) begin
        if (m[0]) w[7:0]  = d[7:0];
        if (m[1]) w[15:8] = d[15:8];
        ref_mem[a] = w;
      end
      last_read = !wr;
    end
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == (m == 2'b00), "R6", "ready after handshake", int'(req_ready),
        int'(m == 2'b00));
  endtask

  // ---------------- monitor ----------------
  logic       ce_p = 1, we_p = 1, oe_p = 1;
  int         we_cnt = 0, drv_cnt = 0, oe_cnt = 0;
  int         ram_age [2] = '{15, 15};
  bit         contention = 0, lane_leak = 0;
  exp_t       got;
  logic [15:0] wb;

  always @(negedge clk) begin
    if (rst_n) begin
      for (int l = 0; l < 2; l++) begin
        if (ram_act[l]) ram_age[l] = 0;
        else if (ram_age[l] < 15) ram_age[l]++;
        if (dq_oe[l] && ram_age[l] < HIZ_GRD) contention = 1;
        if (dq_oe[l] && !cur_mask[l]) lane_leak = 1;
      end
      // RAM write: overlap of select, write enable and lane strobe
      if (!ce_n && !we_n) begin
        wb = ram_rd(ram_addr);
        if (!lb_n && dq_oe[0]) wb[7:0]  = dq_out[7:0];
        if (!ub_n && dq_oe[1]) wb[15:8] = dq_out[15:8];
        ram_mem[ram_addr] = wb;
      end

      if (rsp_done || rsp_err) begin
        chk(!(rsp_done && rsp_err), "R6", "done and err together", 1, 0);
        if (exp_q.size() == 0) begin
          chk(0, "R6", "response without request", int'({rsp_done, rsp_err}), 0);
        end else begin
          got = exp_q.pop_front();
          chk(got.is_err == rsp_err, "R7", "response kind err", int'(rsp_err), int'(got.is_err));
          if (rsp_done && got.is_read)
            chk(rsp_rdata == got.rdata, "R5", "read data", int'(rsp_rdata), int'(got.rdata));
          if (rsp_err)
            chk(ce_n && dq_oe == 2'b00, "R7", "idle pins on reject",
                int'({ce_n, dq_oe}), 4);
        end
      end

      if (ce_p && !ce_n) begin
        chk(cyc - hs_cyc == exp_delay, "R8", "handshake to select", cyc - hs_cyc, exp_delay);
        chk({ub_n, lb_n} == ~cur_mask, "R3", "lane strobes", int'({ub_n, lb_n}),
            int'(~cur_mask));
      end
      if (!ce_p && ce_n) begin
        chk(dq_oe == 2'b00, "R4", "bus released after access", int'(dq_oe), 0);
        chk(!lane_leak, "R3", "unselected lane driven", int'(lane_leak), 0);
        chk(rsp_done, "R6", "done with select release", int'(rsp_done), 1);
        lane_leak = 0;
      end

      if (!we_n) begin
        we_cnt++;
        if (|dq_oe) drv_cnt++;
        chk(oe_n, "R2", "output enable high in write", int'(oe_n), 1);
      end
      if (!we_p && we_n) begin
        chk(we_cnt == WE_LOW, "R2", "write enable low cycles", we_cnt, WE_LOW);
        chk(drv_cnt == WE_LOW - WE_HIZ, "R4", "drive cycles while WE low", drv_cnt,
            WE_LOW - WE_HIZ);
        chk(dq_oe == cur_mask && !ce_n, "R4", "drive held in hold cycle", int'(dq_oe),
            int'(cur_mask));
        chk(!contention, "R4", "drive during RAM release", int'(contention), 0);
        we_cnt = 0; drv_cnt = 0; contention = 0;
      end

      if (!oe_n) oe_cnt++;
      if (!oe_p && oe_n) begin
        chk(oe_cnt == RD_SMP, "R5", "read strobe cycles", oe_cnt, RD_SMP);
        chk(rsp_done, "R5", "done after read strobe", int'(rsp_done), 1);
        oe_cnt = 0;
      end
    end
    ce_p = ce_n;
    we_p = we_n;
    oe_p = oe_n;
  end

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (60000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
      summary();
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    logic [31:0] lcg;
    req_valid = 0; req_write = 0; req_addr = '0; req_wdata = '0; req_mask = '0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk({ce_n, oe_n, we_n, lb_n, ub_n} == 5'b11111 && dq_oe == 2'b00, "R1",
        "pins in reset", int'({ce_n, oe_n, we_n, lb_n, ub_n, dq_oe}), 8'h7C);
    chk(req_ready && !rsp_done && !rsp_err, "R1", "handshake in reset",
        int'({req_ready, rsp_done, rsp_err}), 4);
    rst_n = 1;
    @(negedge clk);
    chk({ce_n, oe_n, we_n, lb_n, ub_n} == 5'b11111 && req_ready, "R1", "pins after reset",
        int'({ce_n, oe_n, we_n, lb_n, ub_n, req_ready}), 8'h3F);

    do_req(1, 17'h00010, 16'h1234, 2'b11);   // R2 full write
    do_req(0, 17'h00010, 16'h0000, 2'b11);   // R5 read back
    do_req(1, 17'h00010, 16'hFFEE, 2'b10);   // R3 upper only, R8 gap after read
    do_req(0, 17'h00010, 16'h0000, 2'b11);   // R3 lower byte kept
    do_req(0, 17'h00010, 16'h0000, 2'b01);   // R5 masked lane reads zero
    do_req(1, 17'h00011, 16'h5566, 2'b01);   // R3 lower only
    do_req(1, 17'h00012, 16'h7788, 2'b11);   // R8 write after write
    do_req(0, 17'h00011, 16'h0000, 2'b10);   // R3 upper seed kept
    do_req(1, 17'h00010, 16'h0000, 2'b00);   // R7 reject
    do_req(0, 17'h00010, 16'h0000, 2'b11);   // R7 contents unchanged
    do_req(1, 17'h1FFFF, 16'hBEEF, 2'b11);   // top address
    do_req(0, 17'h1FFFF, 16'h0000, 2'b11);
    do_req(0, 17'h00012, 16'h0000, 2'b11);

    lcg = 32'h1ACE_B00C;
    for (int i = 0; i < 30; i++) begin
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      do_req(lcg[31], {14'd0, lcg[18:16]}, lcg[15:0], lcg[25:24]);
    end

    while (exp_q.size() != 0 || !req_ready) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R6", "all responses seen", exp_q.size(), 0);
    finished = 1;
    summary();
    $finish;
  end

endmodule